// File: doc/BRIEF.md
# Protected Address Translation Buffer

This block caches recent virtual-to-physical page translations. Every access presents a virtual address and an access kind. The access kind is load, store or instruction fetch. The block compares the virtual page number against every stored entry at once. There is no set index. On a hit, it swaps the page number for a narrower physical page number and passes the page offset through unchanged.

Every entry also carries two permission bits. One allows writes. The other forbids execution. A matching entry is therefore not always enough to complete an access. A store to a page that cannot be written returns a write fault. A fetch from a page marked no-execute returns an execute fault. If no entry matches, the block returns a miss and no address. Privileged software or a page-table agent then installs the translation through the fill port and retries the access. A flush input invalidates every entry.

Top module: `xlat_buffer`

## Requirements
- R1: The lookup compares the virtual page number (address bits above the offset) against all valid entries in parallel, so an entry in any slot, including the last of the default 16, can hit.
- R2: Each lookup produces exactly one response, which appears on the clock edge after the request (`rsp_valid` one cycle after `req_valid`). No response appears without a request.
- R3: On a hit, `rsp_paddr` is the entry's physical page number joined above the 12-bit page offset, and the offset is copied unchanged from the virtual address.
- R4: When no valid entry matches, the response has `rsp_miss` set, `rsp_hit` clear and `rsp_paddr` zero.
- R5: A store (`req_kind` 2'b01) that matches an entry whose write-enable bit is clear gives `rsp_wfault` with no hit and a zero address. A store to a writable page hits.
- R6: A fetch (`req_kind` 2'b10) that matches an entry whose no-execute bit is set gives `rsp_xfault` with no hit and a zero address. Loads (2'b00, and 2'b11, which is treated as a load) and stores ignore the no-execute bit.
- R7: Each response carries exactly one of hit, miss, write fault and execute fault. A miss is reported before any permission check is made.
- R8: A fill whose virtual page number matches a valid entry overwrites that entry in place, including its permission bits. It does not use another slot.
- R9: Any other fill goes to the lowest-numbered invalid slot. When every slot is valid, it replaces the slot named by a victim pointer. The pointer starts at slot 0 and advances by one, with wrap-around, after each such replacement.
- R10: A lookup made in the same cycle as a fill sees the contents from before that fill.
- R11: Reset and flush invalidate every entry and set the victim pointer back to slot 0. A flush wins over a fill in the same cycle. A lookup in the same cycle as a flush sees the contents from before the flush.
- R12: Lookups never change the stored entries. Repeating a lookup returns the same result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Invalidate all entries |
| req_valid | input | 1 | Lookup request strobe |
| req_vaddr | input | VA_W (32) | Virtual address to translate |
| req_kind | input | 2 | 00 load, 01 store, 10 fetch, 11 load |
| fill_valid | input | 1 | Install a translation |
| fill_vpn | input | VA_W-OFS_W (20) | Virtual page number to install |
| fill_ppn | input | PA_W-OFS_W (12) | Physical page number to install |
| fill_wr_en | input | 1 | Page may be written |
| fill_nx | input | 1 | Page may not be executed |
| rsp_valid | output | 1 | Response strobe |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_paddr | output | PA_W (24) | Physical address, zero unless hit |
| rsp_miss | output | 1 | No valid entry matched |
| rsp_wfault | output | 1 | Store to a write-protected page |
| rsp_xfault | output | 1 | Fetch from a no-execute page |

## Verification
Some properties are checked by assertions on every cycle:
- Each response follows its request by one cycle.
- Each response has exactly one outcome.
- The offset passes through on a hit.
- Misses and faults never carry an address.
- A write fault is only reported for a store, and an execute fault only for a fetch.
- A lookup right after a flush misses.

Other properties depend on the history of fills, so only the bench scenarios can show them:
- Which slot a fill lands in.
- An overwrite in place that leaves the slot count unchanged.
- The order of victim-pointer replacement.
- A lookup that sees the contents from before a same-cycle fill.
- A flush that beats a same-cycle fill.

// File: rtl/xlat_buffer.sv
module xlat_buffer #(
  parameter int ENTRIES = 16,
  parameter int VA_W    = 32,
  parameter int PA_W    = 24,
  parameter int OFS_W   = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    flush,
  input  logic                    req_valid,
  input  logic [VA_W-1:0]         req_vaddr,
  input  logic [1:0]              req_kind,
  input  logic                    fill_valid,
  input  logic [VA_W-OFS_W-1:0]   fill_vpn,
  input  logic [PA_W-OFS_W-1:0]   fill_ppn,
  input  logic                    fill_wr_en,
  input  logic                    fill_nx,
  output logic                    rsp_valid,
  output logic                    rsp_hit,
  output logic [PA_W-1:0]         rsp_paddr,
  output logic                    rsp_miss,
  output logic                    rsp_wfault,
  output logic                    rsp_xfault
);
  localparam int VPN_W = VA_W - OFS_W;
  localparam int PPN_W = PA_W - OFS_W;
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);
  localparam logic [1:0] KIND_STORE = 2'b01;
  localparam logic [1:0] KIND_FETCH = 2'b10;

  logic [ENTRIES-1:0] ent_v, ent_we, ent_nx;
  logic [VPN_W-1:0]   ent_vpn [ENTRIES];
  logic [PPN_W-1:0]   ent_ppn [ENTRIES];
  logic [IDX_W-1:0]   victim;

  wire [VPN_W-1:0] look_vpn = req_vaddr[VA_W-1:OFS_W];
  wire [OFS_W-1:0] look_ofs = req_vaddr[OFS_W-1:0];

  logic [ENTRIES-1:0] look_match, fill_match;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign look_match[i] = ent_v[i] && (ent_vpn[i] == look_vpn);
    assign fill_match[i] = ent_v[i] && (ent_vpn[i] == fill_vpn);
  end

  logic [PPN_W-1:0] look_ppn;
  logic             look_we, look_nx;

  always_comb begin
    look_ppn = '0;
    look_we  = 1'b0;
    look_nx  = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (look_match[i]) begin
        look_ppn = look_ppn | ent_ppn[i];
        look_we  = look_we  | ent_we[i];
        look_nx  = look_nx  | ent_nx[i];
      end
    end
  end

  wire is_miss  = ~|look_match;
  wire is_wflt  = !is_miss && (req_kind == KIND_STORE) && !look_we;
  wire is_xflt  = !is_miss && (req_kind == KIND_FETCH) && look_nx;
  wire is_hit   = !is_miss && !is_wflt && !is_xflt;

  logic [IDX_W-1:0] dup_idx, free_idx, fill_sel;
  logic             dup_found, free_found;

  always_comb begin
    dup_idx   = '0;
    dup_found = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!dup_found && fill_match[i]) begin
        dup_idx   = i[IDX_W-1:0];
        dup_found = 1'b1;
      end
    end
  end

  always_comb begin
    free_idx   = '0;
    free_found = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!free_found && !ent_v[i]) begin
        free_idx   = i[IDX_W-1:0];
        free_found = 1'b1;
      end
    end
  end

  wire use_victim = !dup_found && !free_found;
  assign fill_sel = dup_found ? dup_idx : (free_found ? free_idx : victim);
  wire fill_go = fill_valid && !flush;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_v  <= '0;
      victim <= '0;
    end else if (flush) begin
      ent_v  <= '0;
      victim <= '0;
    end else if (fill_go) begin
      ent_v[fill_sel] <= 1'b1;
      if (use_victim) victim <= (victim == LAST) ? '0 : victim + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_go) begin
      ent_vpn[fill_sel] <= fill_vpn;
      ent_ppn[fill_sel] <= fill_ppn;
      ent_we[fill_sel]  <= fill_wr_en;
      ent_nx[fill_sel]  <= fill_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_miss   <= 1'b0;
      rsp_wfault <= 1'b0;
      rsp_xfault <= 1'b0;
      rsp_paddr  <= '0;
    end else begin
      rsp_valid  <= req_valid;
      rsp_hit    <= req_valid && is_hit;
      rsp_miss   <= req_valid && is_miss;
      rsp_wfault <= req_valid && is_wflt;
      rsp_xfault <= req_valid && is_xflt;
      rsp_paddr  <= (req_valid && is_hit) ? {look_ppn, look_ofs} : '0;
    end
  end
endmodule

// File: rtl/xlat_buffer_props.sv
module xlat_buffer_props #(
  parameter int VA_W  = 32,
  parameter int PA_W  = 24,
  parameter int OFS_W = 12
) (
  input logic            clk,
  input logic            rst_n,
  input logic            flush,
  input logic            req_valid,
  input logic [VA_W-1:0] req_vaddr,
  input logic [1:0]      req_kind,
  input logic            rsp_valid,
  input logic            rsp_hit,
  input logic [PA_W-1:0] rsp_paddr,
  input logic            rsp_miss,
  input logic            rsp_wfault,
  input logic            rsp_xfault
);
  assert_rsp_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  assert_no_stray_rsp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  assert_offset_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (!rsp_hit || rsp_paddr[OFS_W-1:0] == $past(req_vaddr[OFS_W-1:0])));
  assert_miss_no_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_miss |-> (!rsp_hit && rsp_paddr == '0));
  assert_wfault_store_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_wfault |-> ($past(req_kind) == 2'b01 && rsp_paddr == '0));
  assert_xfault_fetch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_xfault |-> ($past(req_kind) == 2'b10 && rsp_paddr == '0));
  assert_one_outcome_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($countones({rsp_hit, rsp_miss, rsp_wfault, rsp_xfault}) == 1));
  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> !(rsp_hit || rsp_miss || rsp_wfault || rsp_xfault));
  assert_flush_empties_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && $past(flush)) |=> rsp_miss);
endmodule

bind xlat_buffer xlat_buffer_props #(.VA_W(VA_W), .PA_W(PA_W), .OFS_W(OFS_W)) u_props (
  .clk(clk), .rst_n(rst_n), .flush(flush), .req_valid(req_valid),
  .req_vaddr(req_vaddr), .req_kind(req_kind), .rsp_valid(rsp_valid),
  .rsp_hit(rsp_hit), .rsp_paddr(rsp_paddr), .rsp_miss(rsp_miss),
  .rsp_wfault(rsp_wfault), .rsp_xfault(rsp_xfault)
);

// File: tb/sim_xlat_buffer.sv
`timescale 1ns/1ps
module sim_xlat_buffer;
  logic        clk = 1'b0, rst_n = 1'b0, flush = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic [1:0]  req_kind = '0;
  logic        fill_valid = 1'b0, fill_wr_en = 1'b0, fill_nx = 1'b0;
  logic [19:0] fill_vpn = '0;
  logic [11:0] fill_ppn = '0;
  logic        rsp_valid, rsp_hit, rsp_miss, rsp_wfault, rsp_xfault;
  logic [23:0] rsp_paddr;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [27:0] expq[$];
  string       tagq[$];

  localparam logic [1:0] LD = 2'b00, ST = 2'b01, FE = 2'b10, LD3 = 2'b11;
  localparam logic [3:0] HIT = 4'b0001, XF = 4'b0010, WF = 4'b0100, MISS = 4'b1000;

  always #4 clk = ~clk;

  xlat_buffer u0 (.*);

  task automatic lookup(input logic [31:0] va, input logic [1:0] k,
                        input logic [3:0] fl, input logic [23:0] pa, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_kind = k;
    expq.push_back({fl, pa}); tagq.push_back(tag);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic fill(input logic [19:0] vpn, input logic [11:0] ppn, input logic we, input logic nx);
    @(negedge clk);
    fill_valid = 1'b1; fill_vpn = vpn; fill_ppn = ppn; fill_wr_en = we; fill_nx = nx;
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic fill_and_lookup(input logic [19:0] vpn, input logic [11:0] ppn,
                                 input logic [31:0] va, input logic [3:0] fl, input string tag);
    @(negedge clk);
    fill_valid = 1'b1; fill_vpn = vpn; fill_ppn = ppn; fill_wr_en = 1'b1; fill_nx = 1'b0;
    req_valid = 1'b1; req_vaddr = va; req_kind = LD;
    expq.push_back({fl, 24'h0}); tagq.push_back(tag);
    @(negedge clk);
    fill_valid = 1'b0; req_valid = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      checks++;
      if (expq.size() == 0) begin
        fails++;
        $display("FAIL R2 stray response: actual rsp_valid=1 expected 0");
      end else begin
        logic [27:0] e;
        string t;
        e = expq.pop_front();
        t = tagq.pop_front();
        if ({rsp_miss, rsp_wfault, rsp_xfault, rsp_hit, rsp_paddr} != e) begin
          fails++;
          $display("FAIL %s: actual flags(m,w,x,h)=%b pa=%h expected flags=%b pa=%h",
                   t, {rsp_miss, rsp_wfault, rsp_xfault, rsp_hit}, rsp_paddr, e[27:24], e[23:0]);
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if ({rsp_valid, rsp_hit, rsp_miss, rsp_wfault, rsp_xfault, rsp_paddr} != '0) begin
      fails++;
      $display("FAIL R11 reset state: actual outputs nonzero expected 0");
    end
    rst_n = 1'b1;
    lookup(32'h0000_1234, LD, MISS, 24'h0, "R4 empty table miss");
    fill(20'h00001, 12'hABC, 1'b1, 1'b0);
    lookup(32'h0000_1234, LD, HIT, 24'hABC234, "R3 load hit");
    lookup(32'h0000_1FFF, ST, HIT, 24'hABCFFF, "R5 store to writable page");
    lookup(32'h0000_1000, FE, HIT, 24'hABC000, "R6 fetch from executable page");
    fill(20'h00002, 12'h055, 1'b0, 1'b1);
    lookup(32'h0000_2FFF, ST, WF, 24'h0, "R5 write protection fault");
    lookup(32'h0000_2010, FE, XF, 24'h0, "R6 execute fault");
    lookup(32'h0000_2FFF, LD, HIT, 24'h055FFF, "R6 load ignores no-execute");
    lookup(32'h0000_2ABC, LD3, HIT, 24'h055ABC, "R6 kind 11 acts as load");
    lookup(32'h0000_9123, ST, MISS, 24'h0, "R7 miss before permission");
    fill(20'h00001, 12'h111, 1'b0, 1'b0);
    lookup(32'h0000_1234, LD, HIT, 24'h111234, "R8 overwrite in place");
    lookup(32'h0000_1234, ST, WF, 24'h0, "R8 overwritten permission");
    for (int i = 0; i < 14; i++) fill(20'h00100 + 20'(i), 12'h200 + 12'(i), 1'b1, 1'b0);
    lookup(32'h0010_D00C, LD, HIT, 24'h20D00C, "R1 last slot hits");
    lookup(32'h0000_2004, LD, HIT, 24'h055004, "R8 overwrite used no extra slot");
    fill(20'h00200, 12'h7A7, 1'b1, 1'b0);
    lookup(32'h0000_1234, LD, MISS, 24'h0, "R9 victim slot 0 replaced");
    lookup(32'h0020_0555, LD, HIT, 24'h7A7555, "R9 new entry hits");
    lookup(32'h0000_2004, LD, HIT, 24'h055004, "R9 slot 1 kept");
    fill(20'h00201, 12'h7A8, 1'b1, 1'b0);
    lookup(32'h0000_2004, LD, MISS, 24'h0, "R9 victim pointer advanced to slot 1");
    lookup(32'h0010_0001, LD, HIT, 24'h200001, "R9 slot 2 kept");
    fill_and_lookup(20'h00300, 12'h333, 32'h0030_0042, MISS, "R10 lookup sees pre-fill state");
    lookup(32'h0030_0042, LD, HIT, 24'h333042, "R10 entry present after fill");
    lookup(32'h0010_0001, LD, MISS, 24'h0, "R9 slot 2 replaced third");
    lookup(32'h0010_D00C, LD, HIT, 24'h20D00C, "R12 repeat lookup one");
    lookup(32'h0010_D00C, LD, HIT, 24'h20D00C, "R12 repeat lookup two");
    @(negedge clk);
    flush = 1'b1; fill_valid = 1'b1; fill_vpn = 20'h00400; fill_ppn = 12'h444;
    fill_wr_en = 1'b1; fill_nx = 1'b0;
    @(negedge clk);
    flush = 1'b0; fill_valid = 1'b0;
    lookup(32'h0040_0000, LD, MISS, 24'h0, "R11 flush beats fill");
    lookup(32'h0030_0042, LD, MISS, 24'h0, "R11 flush clears entries");
    fill(20'h00500, 12'h555, 1'b1, 1'b0);
    lookup(32'h0050_0fed, LD, HIT, 24'h555FED, "R11 refill after flush");
    repeat (3) @(negedge clk);
    checks++;
    if (expq.size() != 0) begin
      fails++;
      $display("FAIL R2 missing responses: actual %0d pending expected 0", expq.size());
    end
    finish_run();
  end
endmodule